// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between a product-term array and a bank of sixteen macrocells. It takes sixty-four product-term values and combines them in fixed groups of four. Each group, called a cluster, is ORed to one bit. A two-bit steer code per cluster then sends that bit to one macrocell: its own cell, the cell on its left or the cell on its right. The code can also leave the cluster unused.

A macrocell ORs every cluster steered to it. It can draw on at most three clusters, which is twelve product terms. The cells form two halves of eight. A cluster never reaches a cell in the other half, and a code that would cross a half edge leaves the cluster unused. The steer codes are static configuration. The sixteen sums are captured in a register stage before they leave the block.

Top module: `pta_allocator`

## Requirements
- R1: The value of cluster c is the OR of product terms 4c, 4c+1, 4c+2 and 4c+3 of `terms_i`.
- R2: The steer code of cluster c sits at `steer_i[2c+1:2c]`. Code 2'b01 sends the cluster to cell c, 2'b00 to cell c-1, 2'b10 to cell c+1, and 2'b11 leaves it unused.
- R3: Code 2'b00 on clusters 0 and 8, and code 2'b10 on clusters 7 and 15, make the cluster unused, so it affects no output.
- R4: A cluster in cells 0–7 never reaches cells 8–15, and a cluster in cells 8–15 never reaches cells 0–7.
- R5: Each output bit k is the OR of all clusters steered to cell k. Up to three clusters (c-1, c, c+1) can feed it at the same time.
- R6: A cell with no cluster steered to it outputs 0, whatever the product terms are.
- R7: Each cluster drives at most one cell at any time.
- R8: `sum_o` shows the result for the inputs sampled at the previous rising clock edge.
- R9: While `rst` is high at a rising edge, `sum_o` becomes all zeros, regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| terms_i | input | 64 | Product-term values, four per cluster |
| steer_i | input | 32 | Two-bit steer code per cluster |
| sum_o | output | 16 | Registered sum term per macrocell |

## Verification
Uniform steer settings are applied first (all own, all left, all right, all unused), each with a walking single product term. These settings show whether every term lands in the right cell, or in no cell. The half edges get their own setting, in which the edge clusters point outward. Here a stray bit in the neighbouring half would expose a crossing. One cell is then fed by three clusters, and each term is lit in turn to show that the OR covers all twelve. Sparse pseudo-random terms with random steer codes then mix all the cases, and a separate step checks the one-cycle output latency.

// File: rtl/pta_pkg.sv
package pta_pkg;
    parameter int PTA_CELLS     = 16;
    parameter int PTA_TERMS_PER = 4;
    parameter int PTA_HALF      = 8;

    typedef enum logic [1:0] {
        STEER_LEFT  = 2'b00,
        STEER_OWN   = 2'b01,
        STEER_RIGHT = 2'b10,
        STEER_OFF   = 2'b11
    } steer_e;

    // First cell index of the half that holds cell idx
    function automatic int half_base(input int idx, input int half);
        return (idx / half) * half;
    endfunction
endpackage

// File: rtl/pta_cluster_or.sv
module pta_cluster_or #(
    parameter int CELLS     = pta_pkg::PTA_CELLS,
    parameter int TERMS_PER = pta_pkg::PTA_TERMS_PER
) (
    input  logic [CELLS*TERMS_PER-1:0] terms_i,
    output logic [CELLS-1:0]           cval_o
);
    for (genvar c = 0; c < CELLS; c++) begin : g_cl
        assign cval_o[c] = |terms_i[c*TERMS_PER +: TERMS_PER];
    end
endmodule

// File: rtl/pta_steer_decode.sv
module pta_steer_decode #(
    parameter int CELLS = pta_pkg::PTA_CELLS,
    parameter int HALF  = pta_pkg::PTA_HALF
) (
    input  logic [2*CELLS-1:0]           steer_i,
    output logic [CELLS-1:0][CELLS-1:0]  grant_o   // grant_o[cluster][cell]
);
    import pta_pkg::*;

    for (genvar c = 0; c < CELLS; c++) begin : g_dec
        localparam int  BASE  = half_base(c, HALF);
        localparam bit  HAS_L = (c > BASE);
        localparam bit  HAS_R = (c < BASE + HALF - 1);
        localparam int  L_IDX = HAS_L ? c - 1 : c;
        localparam int  R_IDX = HAS_R ? c + 1 : c;
        steer_e             code;
        logic [CELLS-1:0]   row;

        assign code = steer_e'(steer_i[2*c +: 2]);

        always_comb begin
            row = '0;
            unique case (code)
                STEER_OWN:   row[c] = 1'b1;
                STEER_LEFT:  if (HAS_L) row[L_IDX] = 1'b1;
                STEER_RIGHT: if (HAS_R) row[R_IDX] = 1'b1;
                default:     row = '0;
            endcase
        end

        assign grant_o[c] = row;
    end
endmodule

// File: rtl/pta_sum_merge.sv
module pta_sum_merge #(
    parameter int CELLS = pta_pkg::PTA_CELLS
) (
    input  logic [CELLS-1:0]           cval_i,
    input  logic [CELLS-1:0][CELLS-1:0] grant_i,
    output logic [CELLS-1:0]           sum_o,
    output logic [CELLS-1:0]           hit_o
);
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        logic acc_sum;
        logic acc_hit;
        always_comb begin
            acc_sum = 1'b0;
            acc_hit = 1'b0;
            for (int c = 0; c < CELLS; c++) begin
                acc_sum = acc_sum | (grant_i[c][k] & cval_i[c]);
                acc_hit = acc_hit | grant_i[c][k];
            end
        end
        assign sum_o[k] = acc_sum;
        assign hit_o[k] = acc_hit;
    end
endmodule

// File: rtl/pta_allocator.sv
module pta_allocator #(
    parameter int CELLS     = pta_pkg::PTA_CELLS,
    parameter int TERMS_PER = pta_pkg::PTA_TERMS_PER,
    parameter int HALF      = pta_pkg::PTA_HALF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CELLS*TERMS_PER-1:0]  terms_i,
    input  logic [2*CELLS-1:0]          steer_i,
    output logic [CELLS-1:0]            sum_o
);
    import pta_pkg::*;

    localparam int NTERMS = CELLS * TERMS_PER;

    logic [CELLS-1:0]            cval;
    logic [CELLS-1:0][CELLS-1:0] grant;
    logic [CELLS-1:0]            sum_c;
    logic [CELLS-1:0]            hit;

    pta_cluster_or #(.CELLS(CELLS), .TERMS_PER(TERMS_PER)) u_or (
        .terms_i (terms_i),
        .cval_o  (cval)
    );

    pta_steer_decode #(.CELLS(CELLS), .HALF(HALF)) u_dec (
        .steer_i (steer_i),
        .grant_o (grant)
    );

    pta_sum_merge #(.CELLS(CELLS)) u_merge (
        .cval_i  (cval),
        .grant_i (grant),
        .sum_o   (sum_c),
        .hit_o   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) sum_o <= '0;
        else     sum_o <= sum_c;
    end

    // Reset clears the registered sums
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (sum_o == '0));

    // No active term anywhere means no active sum
    assert_zero_terms_R1: assert property (@(posedge clk) disable iff (rst)
        (terms_i == {NTERMS{1'b0}}) |=> (sum_o == '0));

    for (genvar c = 0; c < CELLS; c++) begin : g_chk_cl
        localparam int BASE = half_base(c, HALF);
        // A cluster feeds at most one cell
        assert_single_target_R7: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant[c]));
        // A cluster stays inside its own half
        assert_same_half_R4: assert property (@(posedge clk) disable iff (rst)
            $countones(grant[c][BASE +: HALF]) == $countones(grant[c]));
    end

    for (genvar k = 0; k < CELLS; k++) begin : g_chk_cell
        // A cell without clusters reads zero one cycle later
        assert_idle_cell_R6: assert property (@(posedge clk) disable iff (rst)
            !hit[k] |=> !sum_o[k]);
    end
endmodule

// File: tb/pta_allocator_test.sv
module pta_allocator_test;
    localparam int CELLS = 16;
    localparam int TPC   = 4;
    localparam int HALF  = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [CELLS*TPC-1:0]  terms = '0;
    logic [2*CELLS-1:0]    steer = '1;
    logic [CELLS-1:0]      sum;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    pta_allocator uut (
        .clk     (clk),
        .rst     (rst),
        .terms_i (terms),
        .steer_i (steer),
        .sum_o   (sum)
    );

    always #10 clk = ~clk;

    // Expected sums computed from the requirements
    function automatic logic [CELLS-1:0] model(input logic [CELLS*TPC-1:0] t,
                                               input logic [2*CELLS-1:0] s);
        logic [CELLS-1:0] r = '0;
        for (int c = 0; c < CELLS; c++) begin
            logic v = |t[c*TPC +: TPC];
            logic [1:0] code = s[2*c +: 2];
            int d = -1;
            if (code == 2'b01) d = c;
            else if (code == 2'b00 && (c % HALF) != 0) d = c - 1;
            else if (code == 2'b10 && (c % HALF) != HALF - 1) d = c + 1;
            if (d >= 0) r[d] = r[d] | v;
        end
        return r;
    endfunction

    function automatic logic [2*CELLS-1:0] fill(input logic [1:0] code);
        logic [2*CELLS-1:0] r;
        for (int c = 0; c < CELLS; c++) r[2*c +: 2] = code;
        return r;
    endfunction

    task automatic check(input string req, input logic [CELLS-1:0] got,
                         input logic [CELLS-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive on a falling edge, sample after the next rising edge
    task automatic apply(input string req, input logic [CELLS*TPC-1:0] t,
                         input logic [2*CELLS-1:0] s);
        @(negedge clk);
        terms = t;
        steer = s;
        @(negedge clk);
        check(req, sum, model(t, s));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        terms = '1;
        steer = fill(2'b01);
        repeat (3) @(negedge clk);
        check("R9 reset clears", sum, '0);
        rst = 1'b0;
    endtask

    task automatic t_walk(input string req, input logic [1:0] code);
        for (int i = 0; i < CELLS*TPC; i += 5)
            apply(req, 64'd1 << i, fill(code));
    endtask

    task automatic t_uniform;
        t_walk("R1 R2 own", 2'b01);
        t_walk("R2 left", 2'b00);
        t_walk("R2 right", 2'b10);
        t_walk("R6 unused", 2'b11);
        apply("R6 all unused all ones", '1, fill(2'b11));
    endtask

    task automatic t_edges;
        logic [2*CELLS-1:0] s = fill(2'b11);
        s[2*0 +: 2]  = 2'b00;
        s[2*8 +: 2]  = 2'b00;
        s[2*7 +: 2]  = 2'b10;
        s[2*15 +: 2] = 2'b10;
        apply("R3 R4 edge codes dropped", '1, s);
        check("R3 edge output zero", sum, '0);
        s[2*7 +: 2] = 2'b01;
        s[2*8 +: 2] = 2'b01;
        apply("R4 halves stay apart", {32'h0000_000F, 32'hF000_0000}, s);
    endtask

    task automatic t_triple;
        logic [2*CELLS-1:0] s = fill(2'b11);
        s[2*3 +: 2] = 2'b10;
        s[2*4 +: 2] = 2'b01;
        s[2*5 +: 2] = 2'b00;
        for (int i = 12; i < 24; i++) begin
            apply("R5 three clusters", 64'd1 << i, s);
            check("R5 cell 4 lit", sum, 16'h0010);
        end
        apply("R5 no terms", '0, s);
    endtask

    task automatic t_latency;
        @(negedge clk);
        terms = '1;
        steer = fill(2'b01);
        @(negedge clk);
        check("R8 new value", sum, 16'hFFFF);
        terms = '0;
        #1;
        check("R8 held before edge", sum, 16'hFFFF);
        @(negedge clk);
        check("R8 updated after edge", sum, 16'h0000);
    endtask

    task automatic t_random;
        logic [31:0] lf = 32'hACE1_1234;
        for (int n = 0; n < 200; n++) begin
            logic [63:0] a, b;
            logic [31:0] st;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a[31:0]  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a[63:32] = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b[31:0]  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b[63:32] = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; st = lf;
            apply("R5 R7 random mix", a & b & {b[31:0], a[63:32]}, st);
        end
    endtask

    initial begin
        t_reset();
        t_uniform();
        t_edges();
        t_triple();
        t_latency();
        t_random();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", sum, '0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule